// File: doc/BRIEF.md
# Far-End Alarm Codeword Validator

This block sits after a DS3 C-bit framer that has already pulled far-end alarm and control codewords out of the line. It receives one 6-bit codeword per strobe. From these it decides when one codeword has repeated often enough to become the accepted message, and when that accepted message has gone stale and must be dropped.

A ten-deep history of recent codewords drives both decisions. A codeword is accepted when no message is held and at least eight of the ten most recent receptions equal it. The held message is dropped once at least three of the ten most recent receptions differ from it. Only slots that have been filled since reset are counted.

The accept event and the drop event each set a sticky status bit and each have their own enable bit. A single interrupt line combines them. A small register port lets a host read the held code, read the status bits (which clears them), and set the enables.

Top module: `feac_msg_validator`

## Requirements
- R1: While a message is held, a strobe after which at least 3 of the up to 10 most recent filled history slots (the new codeword included) differ from the held code drops the message. After the drop, address 1 reads 0x00.
- R2: While no message is held, a strobe after which at least 8 of the 10 most recent filled slots equal the incoming codeword accepts that codeword. Address 1 then reads {bit7 = 1, bit6 = 0, bits5:0 = code}. Seven matches are not enough.
- R3: A held code stays unchanged until it is dropped. Once dropped, a code can be accepted again later.
- R4: Address 0 bit0 (accept status) becomes 1 on acceptance, and address 0 bit2 (drop status) becomes 1 on a drop, in the cycle after the triggering strobe.
- R5: A read of address 0 (reg_rd = 1) clears both status bits at the next edge. A status event in that same cycle leaves its bit at 1.
- R6: Address 0 bit1 (accept enable) and bit3 (drop enable) are written by reg_wr to address 0 and read back. Written values of bits 0 and 2 have no effect on the status bits.
- R7: irq_o = (accept status AND accept enable) OR (drop status AND drop enable).
- R8: Cycles without cw_strobe leave the history, the held message and the status bits unchanged.
- R9: After reset, addresses 0 and 1 read 0x00 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cw_strobe | input | 1 | One-cycle strobe marking a new codeword |
| cw_code | input | 6 | Received codeword |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears status on address 0) |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational from address) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checker watches every cycle for the following. The held message only appears or disappears on a strobe. Each appearance sets the accept status and each disappearance sets the drop status. A non-held message always reads as zero, and a held code never drifts. Strobe-free cycles change nothing, and the interrupt never rises without a status bit behind it. The exact 8-of-10 and 3-of-10 thresholds, counting over a partly filled history, clear-on-read with a coincident event, and the ineffective status writes can only be shown by the bench's directed and random sequences against its own history model.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_CODE = 2'd1;
  localparam int unsigned BIT_VSTAT = 0;
  localparam int unsigned BIT_VEN   = 1;
  localparam int unsigned BIT_RSTAT = 2;
  localparam int unsigned BIT_REN   = 3;

  typedef struct packed {
    logic accept;
    logic drop;
  } feac_evt_t;
endpackage

// File: rtl/feac_history.sv
module feac_history #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned DEPTH  = 10,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [CODE_W-1:0] in_code,
  input  logic [CODE_W-1:0] held_code,
  output logic [CNT_W-1:0]  match_cnt,
  output logic [CNT_W-1:0]  diff_cnt
);
  logic [CODE_W-1:0] slot_code_q [DEPTH];
  logic [DEPTH-1:0]  slot_vld_q;
  logic [CODE_W-1:0] slot_code_d [DEPTH];
  logic [DEPTH-1:0]  slot_vld_d;

  // next view of the history with the incoming codeword shifted in
  always_comb begin
    slot_code_d[0] = in_code;
    slot_vld_d[0]  = 1'b1;
    for (int i = 1; i < DEPTH; i++) begin
      slot_code_d[i] = slot_code_q[i-1];
      slot_vld_d[i]  = slot_vld_q[i-1];
    end
  end

  always_comb begin
    match_cnt = '0;
    diff_cnt  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_vld_d[i] && (slot_code_d[i] == in_code))
        match_cnt = match_cnt + 1'b1;
      if (slot_vld_d[i] && (slot_code_d[i] != held_code))
        diff_cnt = diff_cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_code_q[g] <= '0;
        slot_vld_q[g]  <= 1'b0;
      end else if (shift_en) begin
        slot_code_q[g] <= slot_code_d[g];
        slot_vld_q[g]  <= slot_vld_d[g];
      end
    end
  end
endmodule

// File: rtl/feac_decide.sv
module feac_decide
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned DEPTH     = 10,
  parameter int unsigned ACCEPT_TH = 8,
  parameter int unsigned DROP_TH   = 3,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CODE_W-1:0] in_code,
  input  logic [CNT_W-1:0]  match_cnt,
  input  logic [CNT_W-1:0]  diff_cnt,
  output logic              held_vld,
  output logic [CODE_W-1:0] held_code,
  output feac_evt_t         evt
);
  logic              held_vld_d;
  logic [CODE_W-1:0] held_code_d;

  always_comb begin
    evt.accept  = strobe && !held_vld && (match_cnt >= CNT_W'(ACCEPT_TH));
    evt.drop    = strobe &&  held_vld && (diff_cnt  >= CNT_W'(DROP_TH));
    held_vld_d  = held_vld;
    held_code_d = held_code;
    if (evt.accept) begin
      held_vld_d  = 1'b1;
      held_code_d = in_code;
    end else if (evt.drop) begin
      held_vld_d  = 1'b0;
      held_code_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld  <= 1'b0;
      held_code <= '0;
    end else if (strobe) begin
      held_vld  <= held_vld_d;
      held_code <= held_code_d;
    end
  end
endmodule

// File: rtl/feac_hostregs.sv
module feac_hostregs
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  feac_evt_t         evt,
  input  logic              held_vld,
  input  logic [CODE_W-1:0] held_code,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              stat_accept,
  output logic              stat_drop,
  output logic              irq_o
);
  logic en_accept_q, en_drop_q;
  logic en_accept_d, en_drop_d;
  logic stat_accept_d, stat_drop_d;
  logic rd_ctrl, wr_ctrl;

  assign rd_ctrl = reg_rd && (reg_addr == ADDR_CTRL);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

  always_comb begin
    stat_accept_d = evt.accept | (stat_accept & ~rd_ctrl);
    stat_drop_d   = evt.drop   | (stat_drop   & ~rd_ctrl);
    en_accept_d   = wr_ctrl ? reg_wdata[BIT_VEN] : en_accept_q;
    en_drop_d     = wr_ctrl ? reg_wdata[BIT_REN] : en_drop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_accept <= 1'b0;
      stat_drop   <= 1'b0;
      en_accept_q <= 1'b0;
      en_drop_q   <= 1'b0;
    end else begin
      stat_accept <= stat_accept_d;
      stat_drop   <= stat_drop_d;
      en_accept_q <= en_accept_d;
      en_drop_q   <= en_drop_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[BIT_VSTAT] = stat_accept;
        reg_rdata[BIT_VEN]   = en_accept_q;
        reg_rdata[BIT_RSTAT] = stat_drop;
        reg_rdata[BIT_REN]   = en_drop_q;
      end
      ADDR_CODE: begin
        reg_rdata[CODE_W-1:0] = held_code;
        reg_rdata[REG_DW-1]   = held_vld;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = (stat_accept & en_accept_q) | (stat_drop & en_drop_q);
endmodule

// File: rtl/feac_msg_validator.sv
module feac_msg_validator
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned DEPTH     = 10,
  parameter int unsigned ACCEPT_TH = 8,
  parameter int unsigned DROP_TH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_strobe,
  input  logic [CODE_W-1:0] cw_code,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic              rst_meta_q, rst_sync_n;
  logic [CNT_W-1:0]  match_cnt, diff_cnt;
  logic              held_vld;
  logic [CODE_W-1:0] held_code;
  feac_evt_t         evt;
  logic              stat_accept, stat_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  feac_history #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_sync_n), .shift_en(cw_strobe), .in_code(cw_code),
    .held_code(held_code), .match_cnt(match_cnt), .diff_cnt(diff_cnt)
  );

  feac_decide #(.CODE_W(CODE_W), .DEPTH(DEPTH), .ACCEPT_TH(ACCEPT_TH),
                .DROP_TH(DROP_TH)) u_dec (
    .clk(clk), .rst_n(rst_sync_n), .strobe(cw_strobe), .in_code(cw_code),
    .match_cnt(match_cnt), .diff_cnt(diff_cnt), .held_vld(held_vld),
    .held_code(held_code), .evt(evt)
  );

  feac_hostregs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt), .held_vld(held_vld),
    .held_code(held_code), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_accept(stat_accept), .stat_drop(stat_drop), .irq_o(irq_o)
  );
endmodule

// File: rtl/feac_msg_validator_chk.sv
module feac_msg_validator_chk #(
  parameter int unsigned CODE_W = 6
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cw_strobe,
  input logic              held_vld,
  input logic [CODE_W-1:0] held_code,
  input logic              stat_accept,
  input logic              stat_drop,
  input logic              irq_o
);
  // R2: acceptance only on a strobe
  a_r2_accept_on_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(held_vld) |-> $past(cw_strobe));
  // R1: drop only on a strobe
  a_r1_drop_on_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(held_vld) |-> $past(cw_strobe));
  a_r4_accept_sets_status: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(held_vld) |-> stat_accept);
  a_r4_drop_sets_status: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(held_vld) |-> stat_drop);
  a_r1_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !held_vld |-> (held_code == '0));
  a_r3_code_steady: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (held_vld && $past(held_vld)) |-> $stable(held_code));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cw_strobe |=> ($stable(held_vld) && $stable(held_code)));
  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (stat_accept || stat_drop));
endmodule

bind feac_msg_validator feac_msg_validator_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cw_strobe(cw_strobe),
  .held_vld(held_vld), .held_code(held_code), .stat_accept(stat_accept),
  .stat_drop(stat_drop), .irq_o(irq_o)
);

// File: tb/feac_msg_validator_bench.sv
`timescale 1ns/1ps
module feac_msg_validator_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cw_strobe;
  logic [5:0] cw_code;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  // bench model
  int  m_code [10];
  bit  m_vld  [10];
  bit  m_held;
  int  m_hcode;
  bit  m_vst, m_rst, m_ven, m_ren;

  always #2.5 clk = ~clk;

  feac_msg_validator u_feac_msg_validator (
    .clk(clk), .rst_n(rst_n), .cw_strobe(cw_strobe), .cw_code(cw_code),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 10; i++) begin m_code[i] = 0; m_vld[i] = 0; end
    m_held = 0; m_hcode = 0; m_vst = 0; m_rst = 0; m_ven = 0; m_ren = 0;
  endfunction

  function automatic void model_step(int c);
    int match = 0;
    int diff = 0;
    for (int i = 9; i > 0; i--) begin m_code[i] = m_code[i-1]; m_vld[i] = m_vld[i-1]; end
    m_code[0] = c; m_vld[0] = 1;
    for (int i = 0; i < 10; i++) begin
      if (m_vld[i] && m_code[i] == c) match++;
      if (m_vld[i] && m_code[i] != m_hcode) diff++;
    end
    if (!m_held && match >= 8) begin
      m_held = 1; m_hcode = c; m_vst = 1;
    end else if (m_held && diff >= 3) begin
      m_held = 0; m_hcode = 0; m_rst = 1;
    end
  endfunction

  function automatic int exp_ctrl();
    return {m_ren, m_rst, m_ven, m_vst};
  endfunction

  function automatic int exp_code();
    return m_held ? (8'h80 | m_hcode) : 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cw_strobe = 0; cw_code = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic strobe(int c);
    @(negedge clk);
    cw_strobe = 1; cw_code = 6'(c);
    @(posedge clk);
    model_step(c);
    @(negedge clk);
    cw_strobe = 0;
  endtask

  task automatic rd(logic [1:0] a, output int data);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 data = reg_rdata;
    @(posedge clk);
    if (a == 2'd0) begin m_vst = 0; m_rst = 0; end
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 2'd0) begin m_ven = d[1]; m_ren = d[3]; end
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic check_code(string req);
    int v;
    rd(2'd1, v);
    chk(req, v, exp_code());
  endtask

  task automatic check_ctrl(string req);
    int v;
    int e;
    e = exp_ctrl();
    rd(2'd0, v);
    chk(req, v, e);
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    chk(req, int'(irq_o), int'((m_vst & m_ven) | (m_rst & m_ren)));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int dom;
    void'($urandom(32'hFEAC_0001));
    rst_n = 1;
    do_reset();

    // R9: reset state
    rd(2'd0, v); chk("R9 ctrl after reset", v, 0);
    rd(2'd1, v); chk("R9 code after reset", v, 0);
    check_irq("R9 irq after reset");

    // R6: enables write and read back; status bits not writable
    wr(2'd0, 8'h0F);
    check_ctrl("R6 enables set, status write ignored");
    check_irq("R7 no status no irq");

    // R2: seven matches do not accept, eighth does
    for (int i = 0; i < 7; i++) strobe(21);
    check_code("R2 seven matches not enough");
    strobe(21);
    check_code("R2 eighth match accepts");
    check_irq("R7 irq on accept");
    // R8: idle cycles change nothing
    repeat (5) @(negedge clk);
    check_code("R8 idle keeps code");
    check_ctrl("R4 accept status set");
    check_ctrl("R5 status cleared after read");

    // R1: two differing keep, third drops
    strobe(9); strobe(40);
    check_code("R3 code held with two differing");
    strobe(9);
    check_code("R1 third differing drops");
    check_irq("R7 irq on drop");
    check_ctrl("R4 drop status set");

    // R3: re-acceptance after drop
    for (int i = 0; i < 10; i++) strobe(33);
    check_code("R3 accepted again after drop");

    // R5: read coincident with accept event
    do_reset();
    for (int i = 0; i < 7; i++) strobe(5);
    @(negedge clk);
    cw_strobe = 1; cw_code = 6'd5; reg_rd = 1; reg_addr = 2'd0;
    #1 chk("R5 status before coincident event", int'(reg_rdata), 0);
    @(posedge clk);
    m_vst = 0; m_rst = 0; model_step(5);
    @(negedge clk);
    cw_strobe = 0; reg_rd = 0;
    check_ctrl("R5 coincident event keeps status");
    check_ctrl("R5 cleared on later read");
    check_irq("R7 enables off after reset");

    // random phase
    dom = 3;
    wr(2'd0, 8'h0A);
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 24) == 0) dom = $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) strobe($urandom_range(0, 63));
      else strobe(dom);
      if ($urandom_range(0, 30) == 0) wr(2'd0, 8'($urandom_range(0, 255)));
      check_code("R1/R2 random code");
      check_irq("R7 random irq");
      if (it % 4 == 0) check_ctrl("R4/R5 random status");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule